// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This core sits between a serial deserializer and a serial serializer in a time-division multiplexed switch. Each byte that arrives on an input stream/channel pair is stored in a data memory with one location per pair. For every outgoing channel slot, a connection memory chooses the byte to send. The low byte of the connection memory is either the data-memory address of a source input channel (switched mode) or the byte itself (message mode). A three-bit control field in the connection memory sets message mode, enables the output driver and drives an auxiliary per-channel control line.

The serializer asks for a slot by giving its stream/channel index. Two cycles later the core returns the byte, the output enable and the auxiliary bit. The configuring agent writes and reads back both halves of the connection memory and the data memory through a simple word port. A global broadcast input forces every channel into message mode. After reset every channel is disabled, so all outputs stay high-impedance until they are configured.

Top module: `tsi_core`

## Requirements
- R1: After reset every connection control field is zero, so any requested slot returns out_oe=0 and out_aux=0, and reading the control field gives 0.
- R2: With control bit 2 clear, a slot returns the data-memory byte at the address held in its connection low byte. out_valid and the result appear on the second rising edge after slot_req is sampled.
- R3: With control bit 2 set (message mode), a slot returns its connection low byte itself.
- R4: A message byte is returned every time its slot is requested, until the connection low byte is rewritten. After the rewrite the new byte is returned.
- R5: Control bit 0 drives out_oe for the slot. When out_oe is 0, out_data is 0.
- R6: Control bit 1 drives out_aux for the slot, whatever the value of bit 0.
- R7: While bcast is high when the slot is requested, every enabled slot behaves as in message mode, whatever its bit 2.
- R8: cfg_sel selects the target: 0 is the connection low byte, 1 is the control field and 2 is the data memory. Control-field writes keep bits 2:0 only, and bits 7:3 read back as zero. cfg_rdata shows the addressed word one rising edge after cfg_sel/cfg_addr are sampled.
- R9: A data-memory write from the input side and an output fetch never stall each other. If a write hits the fetched address in the same cycle, the fetch returns the previous byte and the next fetch returns the new one.
- R10: When no slot was requested two edges earlier, out_valid, out_oe and out_aux are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_we | input | 1 | Store a received input byte |
| in_addr | input | AW (8) | Input stream/channel index of the received byte |
| in_data | input | 8 | Received byte |
| slot_req | input | 1 | Request the result for an output slot |
| slot_addr | input | AW (8) | Output stream/channel index |
| bcast | input | 1 | Force message mode on all channels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 low byte, 1 control field, 2 data memory |
| cfg_addr | input | AW (8) | Configuration word index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, one edge late |
| out_valid | output | 1 | Slot result valid |
| out_data | output | 8 | Slot byte (0 when disabled) |
| out_oe | output | 1 | Slot output enable |
| out_aux | output | 1 | Slot auxiliary control bit |

## Verification
The bench builds the core with its default 8 streams of 32 channels. This gives the full 8-bit index, so connection low bytes at the ends of the data memory (locations 0 and 255) can be used as switch sources. Broadcast, message rewrites and write-during-fetch collisions on one data-memory address are all driven at this size.

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_we,
  input  logic [$clog2(STREAMS*CHANNELS)-1:0]     in_addr,
  input  logic [7:0]                              in_data,
  input  logic                                    slot_req,
  input  logic [$clog2(STREAMS*CHANNELS)-1:0]     slot_addr,
  input  logic                                    bcast,
  input  logic                                    cfg_we,
  input  logic [1:0]                              cfg_sel,
  input  logic [$clog2(STREAMS*CHANNELS)-1:0]     cfg_addr,
  input  logic [7:0]                              cfg_wdata,
  output logic [7:0]                              cfg_rdata,
  output logic                                    out_valid,
  output logic [7:0]                              out_data,
  output logic                                    out_oe,
  output logic                                    out_aux
);
  localparam int SLOTS = STREAMS * CHANNELS;
  localparam int AW    = $clog2(SLOTS);
  localparam int HW    = 3;

  logic [7:0]    dmem  [SLOTS];
  logic [7:0]    cm_lo [SLOTS];
  logic [HW-1:0] cm_hi [SLOTS];

  logic          s1_v, s1_bc;
  logic [7:0]    s1_lo;
  logic [HW-1:0] s1_hi;

  wire          msg  = s1_hi[2] | s1_bc;
  wire          en   = s1_v & s1_hi[0];
  wire [AW-1:0] src  = s1_lo[AW-1:0];

  always_ff @(posedge clk) begin
    if (in_we)
      dmem[in_addr] <= in_data;
    else if (cfg_we && cfg_sel == 2'd2)
      dmem[cfg_addr] <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        cm_lo[i] <= '0;
        cm_hi[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == 2'd0) cm_lo[cfg_addr] <= cfg_wdata;
      if (cfg_sel == 2'd1) cm_hi[cfg_addr] <= cfg_wdata[HW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_bc     <= 1'b0;
      s1_lo     <= '0;
      s1_hi     <= '0;
      out_valid <= 1'b0;
      out_oe    <= 1'b0;
      out_aux   <= 1'b0;
      out_data  <= '0;
      cfg_rdata <= '0;
    end else begin
      s1_v      <= slot_req;
      s1_bc     <= bcast;
      s1_lo     <= cm_lo[slot_addr];
      s1_hi     <= cm_hi[slot_addr];
      out_valid <= s1_v;
      out_oe    <= en;
      out_aux   <= s1_v & s1_hi[1];
      out_data  <= en ? (msg ? s1_lo : dmem[src]) : 8'h00;
      case (cfg_sel)
        2'd0:    cfg_rdata <= cm_lo[cfg_addr];
        2'd1:    cfg_rdata <= {{(8-HW){1'b0}}, cm_hi[cfg_addr]};
        2'd2:    cfg_rdata <= dmem[cfg_addr];
        default: cfg_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_req,
  input logic       out_valid,
  input logic       out_oe,
  input logic       out_aux,
  input logic [7:0] out_data
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> (out_valid == $past(slot_req, 2)));

  // R10
  idle_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_oe && !out_aux));

  // R5
  quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_oe |-> (out_data == 8'h00));

  // R1
  reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd2) |-> !out_oe);
endmodule

bind tsi_core tsi_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .out_valid(out_valid),
  .out_oe(out_oe), .out_aux(out_aux), .out_data(out_data)
);

// File: tb/tsi_core_tb.sv
module tsi_core_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_we = 0;
  logic [7:0] in_addr = 0, in_data = 0;
  logic       slot_req = 0;
  logic [7:0] slot_addr = 0;
  logic       bcast = 0;
  logic       cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic [7:0] cfg_rdata, out_data;
  logic       out_valid, out_oe, out_aux;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tsi_core u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [1:0] sel, input logic [7:0] a, output logic [7:0] d);
    cfg_sel = sel; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic in_wr(input logic [7:0] a, input logic [7:0] d);
    in_we = 1; in_addr = a; in_data = d;
    @(negedge clk);
    in_we = 0;
  endtask

  task automatic slot(input logic [7:0] a, output logic [7:0] d, output logic v, output logic oe, output logic aux);
    slot_req = 1; slot_addr = a;
    @(negedge clk);
    slot_req = 0;
    @(negedge clk);
    d = out_data; v = out_valid; oe = out_oe; aux = out_aux;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v, oe, aux;
    slot(8'd40, d, v, oe, aux);
    chk("R1 oe after reset", oe, 0);
    chk("R1 aux after reset", aux, 0);
    cfg_rd(2'd1, 8'd40, d);
    chk("R1 ctrl readback", d, 0);
    @(negedge clk);
    chk("R10 idle valid", out_valid, 0);
    chk("R10 idle oe", out_oe, 0);
  endtask

  task automatic t_switch();
    logic [7:0] d; logic v, oe, aux;
    in_wr(8'd0, 8'hA5);
    in_wr(8'd255, 8'h3C);
    cfg_wr(2'd0, 8'd10, 8'd0);   cfg_wr(2'd1, 8'd10, 8'h01);
    cfg_wr(2'd0, 8'd11, 8'd255); cfg_wr(2'd1, 8'd11, 8'h03);
    slot(8'd10, d, v, oe, aux);
    chk("R2 switched data lo end", d, 8'hA5);
    chk("R2 valid", v, 1);
    chk("R5 oe set", oe, 1);
    chk("R6 aux clear", aux, 0);
    slot(8'd11, d, v, oe, aux);
    chk("R2 switched data hi end", d, 8'h3C);
    chk("R6 aux set", aux, 1);
  endtask

  task automatic t_message();
    logic [7:0] d; logic v, oe, aux;
    cfg_wr(2'd0, 8'd12, 8'h77); cfg_wr(2'd1, 8'd12, 8'h05);
    slot(8'd12, d, v, oe, aux);
    chk("R3 message byte", d, 8'h77);
    slot(8'd12, d, v, oe, aux);
    chk("R4 message repeat", d, 8'h77);
    cfg_wr(2'd0, 8'd12, 8'h12);
    slot(8'd12, d, v, oe, aux);
    chk("R4 message rewritten", d, 8'h12);
  endtask

  task automatic t_disable();
    logic [7:0] d; logic v, oe, aux;
    cfg_wr(2'd0, 8'd13, 8'd0); cfg_wr(2'd1, 8'd13, 8'h00);
    slot(8'd13, d, v, oe, aux);
    chk("R5 disabled oe", oe, 0);
    chk("R5 disabled data", d, 0);
    cfg_wr(2'd1, 8'd13, 8'h02);
    slot(8'd13, d, v, oe, aux);
    chk("R6 aux without oe", aux, 1);
    chk("R5 data zero without oe", d, 0);
  endtask

  task automatic t_bcast();
    logic [7:0] d; logic v, oe, aux;
    bcast = 1;
    slot(8'd10, d, v, oe, aux);
    chk("R7 broadcast slot10", d, 8'd0);
    slot(8'd11, d, v, oe, aux);
    chk("R7 broadcast slot11", d, 8'd255);
    bcast = 0;
    slot(8'd11, d, v, oe, aux);
    chk("R7 broadcast off", d, 8'h3C);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    cfg_wr(2'd1, 8'd20, 8'hFF);
    cfg_rd(2'd1, 8'd20, d);
    chk("R8 reserved bits zero", d, 8'h07);
    cfg_rd(2'd0, 8'd12, d);
    chk("R8 low byte readback", d, 8'h12);
    cfg_rd(2'd2, 8'd255, d);
    chk("R8 data memory readback", d, 8'h3C);
  endtask

  task automatic t_collide();
    logic [7:0] d; logic v, oe, aux;
    slot_req = 1; slot_addr = 8'd10;
    @(negedge clk);
    slot_req = 0;
    in_we = 1; in_addr = 8'd0; in_data = 8'h5A;
    @(negedge clk);
    in_we = 0;
    chk("R9 fetch gets old byte", out_data, 8'hA5);
    chk("R9 fetch valid", out_valid, 1);
    slot(8'd10, d, v, oe, aux);
    chk("R9 next fetch gets new byte", d, 8'h5A);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_switch();
        t_message();
        t_disable();
        t_bcast();
        t_cfg();
        t_collide();
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule